// File: doc/BRIEF.md
# Width-Converting Dual-Clock FIFO

This block is a first-in first-out buffer whose write and read sides run on unrelated clocks. Each side is either 9 or 18 bits wide. The two widths are chosen independently and are captured while master reset is held. When the widths differ, the block splits 18-bit words into 9-bit ones or packs 9-bit words into 18-bit ones. A byte-order select decides which half of an 18-bit word comes first. Storage is an inferred register array counted in 9-bit units. An 18-bit word takes two units and a 9-bit word takes one.

Two output timings are offered, and the choice is also captured at master reset. In standard timing, a read request moves the next word onto the output register. The read flag then means "empty" and the write flag means "full". In fall-through timing, the oldest word appears on the output with no request. The read flag then means "output ready" and the write flag means "input ready". A request in this mode removes the shown word.

A retransmit pulse rewinds the read side to the first unit stored since the last reset. Partial reset empties the buffer but keeps the captured configuration. Master reset empties the buffer and captures a new configuration.

The read side is driven by a three-state controller:
- RD_IDLE means no word is shown. It goes to RD_STD when standard timing is configured. It goes to RD_SHOW in fall-through timing once a whole word is available.
- RD_STD serves standard-timing reads and is left only by reset.
- RD_SHOW holds the shown word. It returns to RD_IDLE on a retransmit, or on a request when no further word is available.
- Every reset enters RD_IDLE.

Pointers cross between domains as Gray code through two-flop synchronisers. Each flag is computed in the domain of its own port.

Top module: `bmf_fifo`

## Requirements
- R1: The four configuration inputs are sampled on clock edges only while mrst_n is low. Changing them after mrst_n rises has no effect on widths, byte order or timing mode.
- R2: In 9-bit-in/9-bit-out mode, words come out in write order on dout[8:0], with dout[17:9] zero. In this mode din[17:9] is ignored.
- R3: In 18-bit-in/18-bit-out mode, each 18-bit word comes out unchanged and in write order.
- R4: In 9-bit-in/18-bit-out mode, each output word packs two input words. With cfg_big_end=1 the earlier word sits in dout[17:9]. With cfg_big_end=0 the earlier word sits in dout[8:0].
- R5: In 18-bit-in/9-bit-out mode, each input word yields two output words. With cfg_big_end=1 din[17:9] comes out first. With cfg_big_end=0 din[8:0] comes out first.
- R6: In standard timing, rd_flag=1 means fewer units are stored than one output word needs. A read with ren while rd_flag=0 loads dout at that rclk edge. A read with ren while rd_flag=1 leaves dout unchanged.
- R7: In fall-through timing, rd_flag=1 means dout holds the oldest word, which appears with no ren. ren while rd_flag=1 removes it. rd_flag is 0 when nothing is left.
- R8: The buffer counts as full when fewer free units remain than one input word needs. In standard timing wr_flag=1 when full; in fall-through timing wr_flag=1 when not full. A write while full is dropped.
- R9: half_full is 1 exactly when at least half of the unit capacity is occupied, as seen in the write domain.
- R10: In standard timing, after a write into an empty buffer, rd_flag falls within four rclk cycles.
- R11: A one-cycle rexmit rewinds the read side to the first unit written since the last reset. In fall-through timing that word is shown on the second rclk edge after the pulse.
- R12: Partial reset (prst_n low) empties the buffer and keeps the configuration captured at master reset.
- R13: After master reset the buffer is empty, full and half_full are low, and dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; configuration sampled while low |
| prst_n | input | 1 | Partial reset, active low; configuration retained |
| cfg_in_wide | input | 1 | 1 = 18-bit write port, 0 = 9-bit |
| cfg_out_wide | input | 1 | 1 = 18-bit read port, 0 = 9-bit |
| cfg_big_end | input | 1 | 1 = upper half first, 0 = lower half first |
| cfg_fwft | input | 1 | 1 = fall-through timing, 0 = standard timing |
| wen | input | 1 | Write request |
| din | input | 18 | Write data (bits 8:0 only in 9-bit mode) |
| ren | input | 1 | Read request |
| rexmit | input | 1 | Retransmit pulse, read domain |
| dout | output | 18 | Read data (bits 8:0 only in 9-bit mode) |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | At least half of capacity occupied |

## Verification
The data path is driven with all four width pairings. The mixed pairings are run in both byte orders, so that a swapped half or a wrong packing order shows up as a miscompare rather than passing silently. The configuration pins are inverted right after every master reset, which separates correct capture from sampling that continues after reset. Fill patterns run up to the unit capacity with both 9-bit and 18-bit writes, including a case with one free unit that is still too small for an 18-bit word. These patterns tell apart a full test counted in units from one counted in words. Retransmit, partial reset and empty reads are each checked in both timing modes where the behaviour differs.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    localparam int UNIT_W = 9;

    typedef logic [UNIT_W-1:0] unit_t;

    typedef struct packed {
        logic in_wide;
        logic out_wide;
        logic big_end;
        logic fwft;
    } cfg_t;

    typedef enum logic [1:0] {
        RD_STD  = 2'd0,
        RD_IDLE = 2'd1,
        RD_SHOW = 2'd2
    } rd_state_t;

endpackage

// File: rtl/bmf_cfg_latch.sv
module bmf_cfg_latch
    import bmf_pkg::*;
(
    input  logic clk,
    input  logic mrst_n,
    input  cfg_t cfg_i,
    output cfg_t cfg_o
);

    // Loads only while master reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cfg_o <= cfg_i;
        end
    end

endmodule

// File: rtl/bmf_sync2.sv
module bmf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/bmf_store.sv
module bmf_store
    import bmf_pkg::*;
#(
    parameter int UNITS = 64,
    localparam int AW = $clog2(UNITS)
) (
    input  logic          wclk,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  unit_t         wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  unit_t         wd1,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    output unit_t         rd0,
    output unit_t         rd1
);

    unit_t mem [UNITS];

    // Two write lanes; the lanes never target the same unit in one cycle.
    always_ff @(posedge wclk) begin
        if (we0) begin
            mem[wa0] <= wd0;
        end
        if (we1) begin
            mem[wa1] <= wd1;
        end
    end

    assign rd0 = mem[ra0];
    assign rd1 = mem[ra1];

endmodule

// File: rtl/bmf_wr_ctl.sv
module bmf_wr_ctl
    import bmf_pkg::*;
#(
    parameter int UNITS = 64,
    localparam int AW = $clog2(UNITS),
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          wen,
    input  logic [17:0]   din,
    input  logic [PW-1:0] rgray_s,
    output logic          we0,
    output logic [AW-1:0] wa0,
    output unit_t         wd0,
    output logic          we1,
    output logic [AW-1:0] wa1,
    output unit_t         wd1,
    output logic [PW-1:0] wgray,
    output logic          w_full,
    output logic          half_full,
    output logic [PW-1:0] w_level
);

    localparam logic [PW-1:0] CAP  = PW'(UNITS);
    localparam logic [PW-1:0] HALF = PW'(UNITS / 2);

    logic [PW-1:0] wptr;
    logic [PW-1:0] wptr_nx;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rptr_w;
    logic [PW-1:0] need;
    logic [PW-1:0] free_units;
    logic [PW-1:0] gsrc;
    logic          accept;

    // Read pointer arrives as Gray of its word count.
    always_comb begin
        rbin[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_s[i];
        end
    end

    assign rptr_w     = cfg.out_wide ? {rbin[PW-2:0], 1'b0} : rbin;
    assign w_level    = wptr - rptr_w;
    assign need       = cfg.in_wide ? PW'(2) : PW'(1);
    assign free_units = CAP - w_level;
    assign w_full     = free_units < need;
    assign half_full  = w_level >= HALF;
    assign accept     = wen && !w_full;
    assign wptr_nx    = accept ? wptr + need : wptr;
    assign gsrc       = cfg.in_wide ? {1'b0, wptr_nx[PW-1:1]} : wptr_nx;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_nx;
            wgray <= gsrc ^ (gsrc >> 1);
        end
    end

    // Lane 0 holds the half that leaves first, lane 1 the other half.
    assign we0 = accept;
    assign wa0 = wptr[AW-1:0];
    assign wd0 = (cfg.in_wide && cfg.big_end) ? din[17:9] : din[8:0];
    assign we1 = accept && cfg.in_wide;
    assign wa1 = wa0 + AW'(1);
    assign wd1 = cfg.big_end ? din[8:0] : din[17:9];

endmodule

// File: rtl/bmf_rd_ctl.sv
module bmf_rd_ctl
    import bmf_pkg::*;
#(
    parameter int UNITS = 64,
    localparam int AW = $clog2(UNITS),
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          ren,
    input  logic          rexmit,
    input  logic [PW-1:0] wgray_s,
    input  unit_t         rd0,
    input  unit_t         rd1,
    output logic [AW-1:0] ra0,
    output logic [AW-1:0] ra1,
    output logic [PW-1:0] rgray,
    output logic [17:0]   dout,
    output logic          rd_flag,
    output logic [PW-1:0] r_level,
    output logic [PW-1:0] r_ptr
);

    rd_state_t     state;
    rd_state_t     state_nx;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wptr_r;
    logic [PW-1:0] need;
    logic [PW-1:0] rptr_nx;
    logic [PW-1:0] gsrc;
    logic [17:0]   word;
    logic          has_word;
    logic          take;

    always_comb begin
        wbin[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s[i];
        end
    end

    assign wptr_r   = cfg.in_wide ? {wbin[PW-2:0], 1'b0} : wbin;
    assign r_level  = wptr_r - r_ptr;
    assign need     = cfg.out_wide ? PW'(2) : PW'(1);
    assign has_word = r_level >= need;
    assign ra0      = r_ptr[AW-1:0];
    assign ra1      = ra0 + AW'(1);

    always_comb begin
        if (!cfg.out_wide) begin
            word = {9'd0, rd0};
        end else if (cfg.big_end) begin
            word = {rd0, rd1};
        end else begin
            word = {rd1, rd0};
        end
    end

    // State register.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and control.
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            RD_IDLE: begin
                if (!cfg.fwft) begin
                    state_nx = RD_STD;
                end else if (!rexmit && has_word) begin
                    take     = 1'b1;
                    state_nx = RD_SHOW;
                end
            end
            RD_STD: begin
                take = ren && has_word && !rexmit;
            end
            RD_SHOW: begin
                if (rexmit) begin
                    state_nx = RD_IDLE;
                end else if (ren) begin
                    if (has_word) begin
                        take = 1'b1;
                    end else begin
                        state_nx = RD_IDLE;
                    end
                end
            end
            default: begin
                state_nx = RD_IDLE;
            end
        endcase
    end

    always_comb begin
        if (rexmit) begin
            rptr_nx = '0;
        end else if (take) begin
            rptr_nx = r_ptr + need;
        end else begin
            rptr_nx = r_ptr;
        end
    end

    assign gsrc = cfg.out_wide ? {1'b0, rptr_nx[PW-1:1]} : rptr_nx;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            r_ptr <= '0;
            rgray <= '0;
            dout  <= '0;
        end else begin
            r_ptr <= rptr_nx;
            rgray <= gsrc ^ (gsrc >> 1);
            if (take) begin
                dout <= word;
            end
        end
    end

    assign rd_flag = cfg.fwft ? (state == RD_SHOW) : !has_word;

endmodule

// File: rtl/bmf_fifo.sv
module bmf_fifo
    import bmf_pkg::*;
#(
    parameter int UNITS = 64,
    localparam int AW = $clog2(UNITS),
    localparam int PW = AW + 1
) (
    input  logic        wclk,
    input  logic        rclk,
    input  logic        mrst_n,
    input  logic        prst_n,
    input  logic        cfg_in_wide,
    input  logic        cfg_out_wide,
    input  logic        cfg_big_end,
    input  logic        cfg_fwft,
    input  logic        wen,
    input  logic [17:0] din,
    input  logic        ren,
    input  logic        rexmit,
    output logic [17:0] dout,
    output logic        rd_flag,
    output logic        wr_flag,
    output logic        half_full
);

    cfg_t          cfg_pins;
    cfg_t          wcfg;
    cfg_t          rcfg;
    logic          rst_n;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray;
    logic [PW-1:0] rgray_s;
    logic          we0;
    logic          we1;
    logic [AW-1:0] wa0;
    logic [AW-1:0] wa1;
    logic [AW-1:0] ra0;
    logic [AW-1:0] ra1;
    unit_t         wd0;
    unit_t         wd1;
    unit_t         rd0;
    unit_t         rd1;
    logic          w_full;
    logic [PW-1:0] w_level;
    logic [PW-1:0] r_level;
    logic [PW-1:0] r_ptr;
    logic          r_fwft;

    assign cfg_pins = {cfg_in_wide, cfg_out_wide, cfg_big_end, cfg_fwft};
    assign rst_n    = mrst_n & prst_n;
    assign r_fwft   = rcfg.fwft;

    bmf_cfg_latch u_wcfg (.clk(wclk), .mrst_n(mrst_n), .cfg_i(cfg_pins), .cfg_o(wcfg));
    bmf_cfg_latch u_rcfg (.clk(rclk), .mrst_n(mrst_n), .cfg_i(cfg_pins), .cfg_o(rcfg));

    bmf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    bmf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    bmf_store #(.UNITS(UNITS)) u_store (
        .wclk(wclk),
        .we0(we0), .wa0(wa0), .wd0(wd0),
        .we1(we1), .wa1(wa1), .wd1(wd1),
        .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1)
    );

    bmf_wr_ctl #(.UNITS(UNITS)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .cfg(wcfg),
        .wen(wen), .din(din), .rgray_s(rgray_s),
        .we0(we0), .wa0(wa0), .wd0(wd0),
        .we1(we1), .wa1(wa1), .wd1(wd1),
        .wgray(wgray), .w_full(w_full),
        .half_full(half_full), .w_level(w_level)
    );

    bmf_rd_ctl #(.UNITS(UNITS)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .cfg(rcfg),
        .ren(ren), .rexmit(rexmit), .wgray_s(wgray_s),
        .rd0(rd0), .rd1(rd1), .ra0(ra0), .ra1(ra1),
        .rgray(rgray), .dout(dout), .rd_flag(rd_flag),
        .r_level(r_level), .r_ptr(r_ptr)
    );

    assign wr_flag = wcfg.fwft ? !w_full : w_full;

endmodule

// File: rtl/bmf_checker.sv
module bmf_checker #(
    parameter int UNITS = 64,
    localparam int AW = $clog2(UNITS),
    localparam int PW = AW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen,
    input logic          ren,
    input logic          rexmit,
    input logic [17:0]   dout,
    input logic          rd_flag,
    input logic          w_full,
    input logic [PW-1:0] w_level,
    input logic [PW-1:0] r_level,
    input logic [PW-1:0] r_ptr,
    input logic          r_fwft
);

    localparam logic [PW-1:0] CAP = PW'(UNITS);

    p_wlevel_bound_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        w_level <= CAP);

    p_full_blocks_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        (w_full && wen) |=> (w_level <= $past(w_level)));

    p_rlevel_bound_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        r_level <= CAP);

    p_empty_read_ignored_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (!r_fwft && rd_flag && ren && !rexmit) |=> $stable(dout));

    p_fwft_hold_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        (r_fwft && rd_flag && !ren && !rexmit) |=> (rd_flag && $stable(dout)));

    p_rewind_r11: assert property (@(posedge rclk) disable iff (!rst_n)
        rexmit |=> (r_ptr == '0));

endmodule

bind bmf_fifo bmf_checker #(.UNITS(UNITS)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wen(wen), .ren(ren), .rexmit(rexmit),
    .dout(dout), .rd_flag(rd_flag), .w_full(w_full),
    .w_level(w_level), .r_level(r_level), .r_ptr(r_ptr),
    .r_fwft(r_fwft)
);

// File: tb/bmf_fifo_test.sv
module bmf_fifo_test;

    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int UNITS       = 16;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        mrst_n = 1'b0;
    logic        prst_n = 1'b1;
    logic        cfg_in_wide = 1'b0;
    logic        cfg_out_wide = 1'b0;
    logic        cfg_big_end = 1'b0;
    logic        cfg_fwft = 1'b0;
    logic        wen = 1'b0;
    logic [17:0] din = '0;
    logic        ren = 1'b0;
    logic        rexmit = 1'b0;
    logic [17:0] dout;
    logic        rd_flag;
    logic        wr_flag;
    logic        half_full;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    bmf_fifo #(.UNITS(UNITS)) uut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide),
        .cfg_big_end(cfg_big_end), .cfg_fwft(cfg_fwft),
        .wen(wen), .din(din), .ren(ren), .rexmit(rexmit),
        .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .half_full(half_full)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Master reset with a configuration; pins inverted afterwards (R1).
    task automatic mreset(input logic iw, input logic ow, input logic be, input logic ff);
        wen = 1'b0; ren = 1'b0; rexmit = 1'b0; prst_n = 1'b1;
        cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_end = be; cfg_fwft = ff;
        mrst_n = 1'b0;
        repeat (4) @(negedge rclk);
        mrst_n = 1'b1;
        cfg_in_wide = !iw; cfg_out_wide = !ow; cfg_big_end = !be; cfg_fwft = !ff;
        repeat (3) @(negedge rclk);
    endtask

    task automatic push(input logic [17:0] d);
        @(negedge wclk);
        din = d; wen = 1'b1;
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic pop_std(input logic [17:0] exp, input string tag);
        int waited = 0;
        @(negedge rclk);
        while (rd_flag && waited < 20) begin
            @(negedge rclk);
            waited++;
        end
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        check(tag, dout, exp);
    endtask

    task automatic pop_fwft(input logic [17:0] exp, input string tag);
        int waited = 0;
        @(negedge rclk);
        while (!rd_flag && waited < 20) begin
            @(negedge rclk);
            waited++;
        end
        check(tag, dout, exp);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic t_reset_state();
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        check("R13 empty after reset", 18'(rd_flag), 18'd1);
        check("R13 not full after reset", 18'(wr_flag), 18'd0);
        check("R13 half_full low", 18'(half_full), 18'd0);
        check("R13 dout zero", dout, 18'd0);
    endtask

    task automatic t_9to9();
        mreset(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) push({9'h1AA, 9'(9'h10 + i * 7)});
        for (int i = 0; i < 5; i++) pop_std({9'd0, 9'(9'h10 + i * 7)}, "R2 R1 9to9 order");
    endtask

    task automatic t_18to18();
        mreset(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) push(18'(18'h2A5C3 + i * 18'h1111));
        for (int i = 0; i < 4; i++) pop_std(18'(18'h2A5C3 + i * 18'h1111), "R3 18to18 order");
    endtask

    task automatic t_pack(input logic be);
        mreset(1'b0, 1'b1, be, 1'b0);
        push({9'd0, 9'h0A1}); push({9'd0, 9'h1B2});
        push({9'd0, 9'h0C3}); push({9'd0, 9'h1D4});
        pop_std(be ? {9'h0A1, 9'h1B2} : {9'h1B2, 9'h0A1}, "R4 pack first pair");
        pop_std(be ? {9'h0C3, 9'h1D4} : {9'h1D4, 9'h0C3}, "R4 pack second pair");
    endtask

    task automatic t_unpack(input logic be);
        mreset(1'b1, 1'b0, be, 1'b0);
        push({9'h155, 9'h0AA});
        push({9'h1F0, 9'h00F});
        pop_std(be ? 18'h00155 : 18'h000AA, "R5 unpack word0 first");
        pop_std(be ? 18'h000AA : 18'h00155, "R5 unpack word0 second");
        pop_std(be ? 18'h001F0 : 18'h0000F, "R5 unpack word1 first");
        pop_std(be ? 18'h0000F : 18'h001F0, "R5 unpack word1 second");
    endtask

    task automatic t_empty_read();
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        push(18'h000AB);
        pop_std(18'h000AB, "R6 single read");
        repeat (4) @(negedge rclk);
        check("R6 empty flag", 18'(rd_flag), 18'd1);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        @(negedge rclk);
        check("R6 read while empty ignored", dout, 18'h000AB);
    endtask

    task automatic t_latency();
        int cnt = 0;
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        push(18'h00123);
        while (rd_flag && cnt < 10) begin
            @(negedge rclk);
            cnt++;
        end
        check("R10 first word latency within 4", 18'(cnt <= 4), 18'd1);
        pop_std(18'h00123, "R10 first word data");
    endtask

    task automatic t_fwft();
        mreset(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 no output ready when empty", 18'(rd_flag), 18'd0);
        check("R8 input ready in fwft", 18'(wr_flag), 18'd1);
        push(18'h00031); push(18'h00142); push(18'h00053);
        pop_fwft(18'h00031, "R7 first word shown without ren");
        pop_fwft(18'h00142, "R7 second word");
        pop_fwft(18'h00053, "R7 third word");
        repeat (4) @(negedge rclk);
        check("R7 output ready drops", 18'(rd_flag), 18'd0);
    endtask

    task automatic t_full_units();
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < UNITS; i++) push(18'(i + 1));
        check("R8 full after capacity", 18'(wr_flag), 18'd1);
        push(18'h001EE);
        for (int i = 0; i < UNITS; i++) pop_std(18'(i + 1), "R8 data after full, extra dropped");
        repeat (6) @(negedge rclk);
        check("R8 empty after draining, extra dropped", 18'(rd_flag), 18'd1);
    endtask

    task automatic t_full_wide();
        mreset(1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < UNITS / 2; i++) push({9'(i + 2), 9'(i + 3)});
        check("R8 full with 18-bit writes", 18'(wr_flag), 18'd1);
        pop_std(18'd2, "R8 R5 first unit");
        settle();
        check("R8 one free unit still full", 18'(wr_flag), 18'd1);
        pop_std(18'd3, "R8 R5 second unit");
        settle();
        check("R8 two free units not full", 18'(wr_flag), 18'd0);
    endtask

    task automatic t_half();
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < UNITS / 2 - 1; i++) push(18'(i));
        check("R9 below half", 18'(half_full), 18'd0);
        push(18'h00077);
        check("R9 at half", 18'(half_full), 18'd1);
    endtask

    task automatic t_rexmit_std();
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        push(18'h00011); push(18'h00022); push(18'h00033); push(18'h00044);
        pop_std(18'h00011, "R11 before rewind");
        pop_std(18'h00022, "R11 before rewind");
        @(negedge rclk);
        rexmit = 1'b1;
        @(negedge rclk);
        rexmit = 1'b0;
        pop_std(18'h00011, "R11 rewind word0");
        pop_std(18'h00022, "R11 rewind word1");
        pop_std(18'h00033, "R11 rewind word2");
        pop_std(18'h00044, "R11 rewind word3");
    endtask

    task automatic t_rexmit_fwft();
        mreset(1'b0, 1'b0, 1'b0, 1'b1);
        push(18'h000A1); push(18'h000B2); push(18'h000C3);
        pop_fwft(18'h000A1, "R11 fwft drain");
        pop_fwft(18'h000B2, "R11 fwft drain");
        pop_fwft(18'h000C3, "R11 fwft drain");
        @(negedge rclk);
        rexmit = 1'b1;
        @(negedge rclk);
        rexmit = 1'b0;
        @(negedge rclk);
        check("R11 fwft ready after rewind", 18'(rd_flag), 18'd1);
        check("R11 fwft first word after rewind", dout, 18'h000A1);
    endtask

    task automatic t_partial();
        mreset(1'b0, 1'b1, 1'b0, 1'b0);
        push(18'h00011); push(18'h00022); push(18'h00033);
        @(negedge rclk);
        prst_n = 1'b0;
        repeat (3) @(negedge rclk);
        prst_n = 1'b1;
        settle();
        check("R12 empty after partial reset", 18'(rd_flag), 18'd1);
        push(18'h00044); push(18'h00055);
        pop_std({9'h055, 9'h044}, "R12 config kept");
    endtask

    task automatic t_mreset_clears();
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < UNITS; i++) push(18'(i));
        mreset(1'b0, 1'b0, 1'b0, 1'b0);
        check("R13 empty after refill reset", 18'(rd_flag), 18'd1);
        check("R13 full cleared", 18'(wr_flag), 18'd0);
        check("R13 half cleared", 18'(half_full), 18'd0);
    endtask

    initial begin
        t_reset_state();
        t_9to9();
        t_18to18();
        t_pack(1'b1);
        t_pack(1'b0);
        t_unpack(1'b1);
        t_unpack(1'b0);
        t_empty_read();
        t_latency();
        t_fwft();
        t_full_units();
        t_full_wide();
        t_half();
        t_rexmit_std();
        t_rexmit_fwft();
        t_partial();
        t_mreset_clears();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule